// File: doc/BRIEF.md
# Maskable Event Interrupt Controller with Acknowledge Readout

This block gathers asynchronous housekeeping events into an 8-bit pending register and raises an active-low interrupt line whenever any pending event is also enabled in an 8-bit enable mask. Three event sources exist. A free-running divider raises a once-per-second tick. A peripheral bus delivers replies, either solicited by an earlier request or produced by background auto-polling, and these are captured into a reply buffer.

Host software services the interrupt with an acknowledge command. The block then streams a response one byte per clock. If a bus reply is waiting, only the bus-related event bits are reported and cleared, followed by the buffered reply bytes. Otherwise the whole pending byte is reported and cleared in one go. A second command loads the enable mask. Command transport and the peripheral bus protocol live outside this block. While a readout is being prepared or streamed, the block asks the bus side to hold off.

Event bit positions: bit 0 is the tick, bit 2 marks an auto-poll reply and bit 4 marks a bus reply. All other bits stay zero.

Top module: `evirq_ctrl`

## Requirements
- R1: `irq_n` is low exactly when (pending AND mask) is nonzero. It follows any change of either register in the cycle after the clock edge that made the change.
- R2: An acknowledge issued while pending bit 4 is set responds with (pending AND 0x14), followed by the stored reply bytes. The response length is the reply size plus one. The acknowledge clears only bits 4 and 2 and the reply size, so a pending tick (bit 0) survives.
- R3: An acknowledge issued while bit 4 is clear responds with the whole pending byte, with length 1, and clears every pending bit.
- R4: A command is accepted only with the right argument count: 0 for acknowledge (`cmd_op`=0) and 1 for mask load (`cmd_op`=1). Any other count leaves the mask, the pending bits and the response stream untouched.
- R5: An auto-poll reply (`bus_auto`=1) is captured only if bit 4 is clear when its first beat arrives. If it is captured, its bytes are stored from buffer position 0 and bits 4 and 2 are set. An auto-poll reply with no bytes changes nothing.
- R6: A solicited reply (`bus_auto`=0) is always captured and sets only bit 4. It is stored as 0x01, then the byte count, then the data. A solicited reply with no data is stored as the single byte 0x00.
- R7: The tick sets bit 0 once every `TICK_CYCLES` clock cycles, with a constant period.
- R8: After reset, no bits are pending, the mask is 0x11, `irq_n` is high and no response is streaming.
- R9: The response starts in the cycle after the accepted acknowledge and carries one byte per cycle, with `rsp_last` on the final byte. `bus_hold` is high during the acknowledge cycle and the whole stream. An acknowledge arriving while a stream is running is ignored.
- R10: Reply bytes beyond the buffer are dropped. An auto-poll reply keeps at most `DEPTH` bytes, and a solicited reply keeps at most `DEPTH`-2 data bytes, with the stored count equal to the kept bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 1 | 0 = acknowledge, 1 = load mask |
| cmd_argc | input | ARGC_W | Number of argument bytes the command carried |
| cmd_arg | input | 8 | First argument byte (mask value) |
| bus_valid | input | 1 | One reply data byte on `bus_byte` |
| bus_end | input | 1 | Reply finished (no data in this cycle) |
| bus_auto | input | 1 | Reply comes from auto-polling; held for the whole reply |
| bus_byte | input | 8 | Reply data byte |
| bus_hold | output | 1 | Bus side must not deliver reply beats |
| irq_n | output | 1 | Active-low interrupt |
| rsp_valid | output | 1 | Response byte valid |
| rsp_byte | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the response |

## Verification
The bench builds two copies side by side with `DEPTH` = 8. The first uses a tick period of 100000 cycles, so no tick can fire during the run. This makes every pending pattern exact and allows a full sweep of all 256 mask values against several pending patterns, plus reply lengths from empty to two bytes past the buffer in both capture modes. The second copy shares every input but ticks every 200 cycles. That short period lets the bench measure successive tick intervals and show that a bus-mode acknowledge leaves the tick bit pending.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
   localparam int unsigned EV_TICK = 0;
   localparam int unsigned EV_AUTO = 2;
   localparam int unsigned EV_BUS  = 4;
   localparam logic [7:0]  BUS_GROUP = 8'h14;
   localparam logic [7:0]  MASK_INIT = 8'h11;
   typedef enum logic { OP_ACK = 1'b0, OP_MASK = 1'b1 } evirq_op_e;
endpackage

// File: rtl/evirq_tick.sv
module evirq_tick #(
   parameter int unsigned PERIOD = 100_000_000,
   localparam int unsigned CW = $clog2(PERIOD)
) (
   input  logic clk,
   input  logic rst_n,
   output logic pulse
);
   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap  = (cnt_q == CW'(PERIOD - 1));
   assign pulse = wrap;

   // free-running wrap counter: the period never drifts
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/evirq_capture.sv
module evirq_capture #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned IW = $clog2(DEPTH),
   localparam int unsigned SW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          bus_valid,
   input  logic          bus_end,
   input  logic          bus_auto,
   input  logic [7:0]    bus_byte,
   input  logic          bus_pend,
   input  logic          clr_size,
   input  logic [IW-1:0] rd_idx,
   output logic [7:0]    rd_data,
   output logic [SW-1:0] size,
   output logic          set_bus,
   output logic          set_auto
);
   logic [SW-1:0] cnt_q, size_q, cap, off;
   logic          busy_q, keep_q;
   logic          beat, fin_evt, accept, wr_en, fin, fin_sol, fin_auto;
   logic [IW-1:0] widx;
   logic [DEPTH-1:0][7:0] mem;

   assign beat    = bus_valid & ~bus_end & ~hold;
   assign fin_evt = bus_end & ~hold;
   // acceptance is decided once, at the first event of a reply
   assign accept  = busy_q ? keep_q : (~bus_auto | ~bus_pend);
   assign cap     = bus_auto ? SW'(DEPTH) : SW'(DEPTH - 2);
   assign off     = bus_auto ? SW'(0) : SW'(2);
   assign wr_en   = beat & accept & (cnt_q < cap);
   assign widx    = IW'(cnt_q + off);
   assign fin      = fin_evt & accept;
   assign fin_sol  = fin & ~bus_auto;
   assign fin_auto = fin & bus_auto & (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         keep_q <= 1'b0;
         cnt_q  <= '0;
         size_q <= '0;
      end else begin
         if (fin_evt) begin
            busy_q <= 1'b0;
            keep_q <= 1'b0;
            cnt_q  <= '0;
         end else if (beat) begin
            busy_q <= 1'b1;
            keep_q <= accept;
            if (wr_en) cnt_q <= cnt_q + 1'b1;
         end
         if (clr_size)      size_q <= '0;
         else if (fin_sol)  size_q <= (cnt_q == '0) ? SW'(1) : cnt_q + SW'(2);
         else if (fin_auto) size_q <= cnt_q;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [7:0] ent_q;
      always_ff @(posedge clk) begin
         if (fin_sol && g == 0)                ent_q <= {7'b0, cnt_q != '0};
         else if (fin_sol && g == 1)           ent_q <= 8'(cnt_q);
         else if (wr_en && widx == IW'(g))     ent_q <= bus_byte;
      end
      assign mem[g] = ent_q;
   end

   assign rd_data  = mem[rd_idx];
   assign size     = size_q;
   assign set_bus  = fin_sol | fin_auto;
   assign set_auto = fin_auto;
endmodule

// File: rtl/evirq_readout.sv
module evirq_readout #(
   parameter int unsigned DEPTH = 32,
   localparam int unsigned IW = $clog2(DEPTH),
   localparam int unsigned LW = $clog2(DEPTH + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic [7:0]    hdr,
   input  logic [LW-1:0] len,
   input  logic [7:0]    rd_data,
   output logic [IW-1:0] rd_idx,
   output logic          active,
   output logic          rsp_valid,
   output logic [7:0]    rsp_byte,
   output logic          rsp_last
);
   logic          act_q;
   logic [LW-1:0] pos_q, len_q;
   logic [7:0]    hdr_q;
   logic          at_end;

   assign at_end = (pos_q == len_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         pos_q <= '0;
         len_q <= '0;
         hdr_q <= '0;
      end else if (fire) begin
         act_q <= 1'b1;
         pos_q <= '0;
         len_q <= len;
         hdr_q <= hdr;
      end else if (act_q) begin
         if (at_end) act_q <= 1'b0;
         else        pos_q <= pos_q + 1'b1;
      end
   end

   assign rd_idx    = IW'(pos_q - 1'b1);
   assign active    = act_q;
   assign rsp_valid = act_q;
   assign rsp_last  = act_q & at_end;
   assign rsp_byte  = (pos_q == '0) ? hdr_q : rd_data;
endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl
   import evirq_pkg::*;
#(
   parameter int unsigned DEPTH       = 32,
   parameter int unsigned TICK_CYCLES = 100_000_000,
   parameter int unsigned ARGC_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_op,
   input  logic [ARGC_W-1:0] cmd_argc,
   input  logic [7:0]        cmd_arg,
   input  logic              bus_valid,
   input  logic              bus_end,
   input  logic              bus_auto,
   input  logic [7:0]        bus_byte,
   output logic              bus_hold,
   output logic              irq_n,
   output logic              rsp_valid,
   output logic [7:0]        rsp_byte,
   output logic              rsp_last
);
   localparam int unsigned IW = $clog2(DEPTH);
   localparam int unsigned SW = $clog2(DEPTH + 1);
   localparam int unsigned LW = $clog2(DEPTH + 2);

   if (DEPTH < 3 || DEPTH > 256) begin : g_bad_depth
      $error("evirq_ctrl: DEPTH must lie in 3..256");
   end
   if (TICK_CYCLES < 2) begin : g_bad_tick
      $error("evirq_ctrl: TICK_CYCLES must be at least 2");
   end

   logic [7:0]    pend_q, mask_q, clr, set;
   logic          tick_pulse, set_bus, set_auto, active;
   logic          ack_fire, mask_wr, bus_pend;
   logic [SW-1:0] size;
   logic [IW-1:0] rd_idx;
   logic [7:0]    rd_data, hdr;
   logic [LW-1:0] len;

   assign bus_pend = pend_q[EV_BUS];
   assign ack_fire = cmd_valid & (cmd_op == OP_ACK) & (cmd_argc == '0) & ~active;
   assign mask_wr  = cmd_valid & (cmd_op == OP_MASK) & (cmd_argc == ARGC_W'(1));
   assign hdr      = bus_pend ? (pend_q & BUS_GROUP) : pend_q;
   assign len      = bus_pend ? LW'(size) + LW'(1) : LW'(1);
   assign clr      = ack_fire ? (bus_pend ? BUS_GROUP : 8'hFF) : 8'h00;

   always_comb begin
      set           = 8'h00;
      set[EV_TICK]  = tick_pulse;
      set[EV_AUTO]  = set_auto;
      set[EV_BUS]   = set_bus;
   end

   // a new event in the ack cycle wins over the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 8'h00;
         mask_q <= MASK_INIT;
      end else begin
         pend_q <= (pend_q & ~clr) | set;
         if (mask_wr) mask_q <= cmd_arg;
      end
   end

   assign irq_n    = ~|(pend_q & mask_q);
   assign bus_hold = active | ack_fire;

   evirq_tick #(.PERIOD(TICK_CYCLES)) u_tick (
      .clk(clk), .rst_n(rst_n), .pulse(tick_pulse)
   );

   evirq_capture #(.DEPTH(DEPTH)) u_cap (
      .clk(clk), .rst_n(rst_n), .hold(bus_hold),
      .bus_valid(bus_valid), .bus_end(bus_end), .bus_auto(bus_auto),
      .bus_byte(bus_byte), .bus_pend(bus_pend), .clr_size(ack_fire & bus_pend),
      .rd_idx(rd_idx), .rd_data(rd_data), .size(size),
      .set_bus(set_bus), .set_auto(set_auto)
   );

   evirq_readout #(.DEPTH(DEPTH)) u_rd (
      .clk(clk), .rst_n(rst_n), .fire(ack_fire), .hdr(hdr), .len(len),
      .rd_data(rd_data), .rd_idx(rd_idx), .active(active),
      .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_last(rsp_last)
   );
endmodule

// File: rtl/evirq_ctrl_chk.sv
module evirq_ctrl_chk #(
   parameter int unsigned TICK_CYCLES = 100_000_000,
   parameter int unsigned ARGC_W      = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_op,
   input logic [ARGC_W-1:0] cmd_argc,
   input logic              irq_n,
   input logic              rsp_valid,
   input logic              rsp_last,
   input logic [7:0]        pend_q,
   input logic [7:0]        mask_q,
   input logic              ack_fire,
   input logic              tick_pulse,
   input logic              set_auto
);
   logic [31:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          since_q <= '0;
      else if (tick_pulse) since_q <= '0;
      else                 since_q <= since_q + 1'b1;
   end

   // R1
   irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> pend_q != 8'h00);
   // R1
   irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q == 8'h00 |-> irq_n);
   // R2
   bus_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire && pend_q[4] |=> (pend_q & 8'h14) == 8'h00
                              && pend_q[0] == ($past(pend_q[0]) | $past(tick_pulse)));
   // R3
   full_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire && !pend_q[4] |=> (pend_q & 8'hFE) == 8'h00);
   // R4
   mask_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_op && cmd_argc == ARGC_W'(1)) |=> $stable(mask_q));
   // R4
   bad_ack_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_op && cmd_argc != '0 |=> !$rose(rsp_valid));
   // R5
   autopoll_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_auto |-> !pend_q[4]);
   // R7
   tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_pulse |-> since_q == 32'(TICK_CYCLES - 1));
   // R9
   stream_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> $past(ack_fire));
   // R9
   stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last |=> !rsp_valid);
endmodule

bind evirq_ctrl evirq_ctrl_chk #(.TICK_CYCLES(TICK_CYCLES), .ARGC_W(ARGC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_argc(cmd_argc), .irq_n(irq_n), .rsp_valid(rsp_valid),
   .rsp_last(rsp_last), .pend_q(pend_q), .mask_q(mask_q),
   .ack_fire(ack_fire), .tick_pulse(tick_pulse), .set_auto(set_auto)
);

// File: tb/evirq_ctrl_test.sv
module evirq_ctrl_test;
   localparam int DEPTH = 8;
   localparam int TPER  = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0, cmd_op = 1'b0;
   logic [7:0] cmd_argc = 8'd0, cmd_arg = 8'd0;
   logic       bus_valid = 1'b0, bus_end = 1'b0, bus_auto = 1'b0;
   logic [7:0] bus_byte = 8'd0;
   logic       a_hold, a_irq, a_valid, a_last;
   logic [7:0] a_byte;
   logic       t_hold, t_irq, t_valid, t_last;
   logic [7:0] t_byte;

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [7:0] got [64];
   logic [7:0] exp_b [64];
   int got_n, exp_n;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   evirq_ctrl #(.DEPTH(DEPTH), .TICK_CYCLES(100000)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_argc(cmd_argc), .cmd_arg(cmd_arg), .bus_valid(bus_valid),
      .bus_end(bus_end), .bus_auto(bus_auto), .bus_byte(bus_byte),
      .bus_hold(a_hold), .irq_n(a_irq), .rsp_valid(a_valid),
      .rsp_byte(a_byte), .rsp_last(a_last));

   evirq_ctrl #(.DEPTH(DEPTH), .TICK_CYCLES(TPER)) uut_tick (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_argc(cmd_argc), .cmd_arg(cmd_arg), .bus_valid(bus_valid),
      .bus_end(bus_end), .bus_auto(bus_auto), .bus_byte(bus_byte),
      .bus_hold(t_hold), .irq_n(t_irq), .rsp_valid(t_valid),
      .rsp_byte(t_byte), .rsp_last(t_last));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cmd(input logic op, input int argc, input logic [7:0] arg);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_op = op; cmd_argc = 8'(argc); cmd_arg = arg;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
   endtask

   task automatic set_mask(input logic [7:0] m);
      cmd(1'b1, 1, m);
   endtask

   task automatic bus_xfer(input logic auto_r, input int n, input logic [7:0] base);
      bus_auto = auto_r;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         bus_valid = 1'b1; bus_byte = base + 8'(i);
      end
      @(posedge clk); #1;
      bus_valid = 1'b0; bus_end = 1'b1;
      @(posedge clk); #1;
      bus_end = 1'b0;
   endtask

   task automatic collect(input bit tk, input string req);
      got_n = 0;
      for (int k = 0; k < 64; k++) begin
         @(negedge clk);
         if (!(tk ? t_valid : a_valid)) break;
         if (!tk) chk(req, "bus_hold during stream", int'(a_hold), 1);
         got[got_n] = tk ? t_byte : a_byte;
         got_n++;
         if (tk ? t_last : a_last) break;
      end
   endtask

   task automatic compare(input string req);
      chk(req, "response length", got_n, exp_n);
      for (int i = 0; i < exp_n && i < got_n; i++)
         chk(req, $sformatf("response byte %0d", i), int'(got[i]), int'(exp_b[i]));
   endtask

   task automatic ack_read(input bit tk, input string req);
      cmd(1'b0, 0, 8'h00);
      collect(tk, req);
      compare(req);
   endtask

   task automatic wait_tick(output int c);
      c = -1;
      for (int g = 0; g < 1000; g++) begin
         @(negedge clk);
         if (!t_irq) begin c = cyc; break; end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int c0, c1, c2, c3, kk;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8", "irq_n", int'(a_irq), 1);
      chk("R8", "rsp_valid", int'(a_valid), 0);
      chk("R8", "bus_hold", int'(a_hold), 0);

      // R6 empty solicited reply, R8 mask enables bus bit
      bus_xfer(1'b0, 0, 8'h00);
      @(negedge clk);
      chk("R8", "irq_n with bus bit under reset mask", int'(a_irq), 0);
      exp_n = 2; exp_b[0] = 8'h10; exp_b[1] = 8'h00;
      ack_read(1'b0, "R6");
      @(negedge clk);
      chk("R3", "irq_n after ack", int'(a_irq), 1);

      // R1 sweep, nothing pending
      for (int m = 0; m < 256; m++) begin
         set_mask(8'(m));
         @(negedge clk);
         chk("R1", "irq_n idle", int'(a_irq), 1);
      end
      // R1 sweep with auto-poll reply pending (0x14)
      bus_xfer(1'b1, 3, 8'h40);
      for (int m = 0; m < 256; m++) begin
         set_mask(8'(m));
         @(negedge clk);
         chk("R1", $sformatf("irq_n mask %0h", m), int'(a_irq), ((m & 8'h14) != 0) ? 0 : 1);
      end
      set_mask(8'h14);

      // R4 wrong argument counts
      cmd(1'b0, 1, 8'h00);
      repeat (2) @(negedge clk);
      chk("R4", "no stream on bad ack", int'(a_valid), 0);
      cmd(1'b1, 0, 8'h00);
      @(negedge clk);
      chk("R4", "mask kept (argc 0)", int'(a_irq), 0);
      cmd(1'b1, 2, 8'h00);
      @(negedge clk);
      chk("R4", "mask kept (argc 2)", int'(a_irq), 0);

      // R2 bus-mode readout
      exp_n = 4; exp_b[0] = 8'h14; exp_b[1] = 8'h40; exp_b[2] = 8'h41; exp_b[3] = 8'h42;
      ack_read(1'b0, "R2");

      // R5, R10 auto-poll lengths
      for (int n = 1; n <= DEPTH + 2; n++) begin
         bus_xfer(1'b1, n, 8'(n * 16));
         kk = (n > DEPTH) ? DEPTH : n;
         exp_n = kk + 1; exp_b[0] = 8'h14;
         for (int i = 0; i < kk; i++) exp_b[i + 1] = 8'(n * 16 + i);
         ack_read(1'b0, n > DEPTH ? "R10" : "R5");
      end

      // R6, R10 solicited lengths
      for (int n = 0; n <= DEPTH; n++) begin
         bus_xfer(1'b0, n, 8'(n * 16 + 1));
         kk = (n > DEPTH - 2) ? DEPTH - 2 : n;
         exp_b[0] = 8'h10;
         if (n == 0) begin
            exp_n = 2; exp_b[1] = 8'h00;
         end else begin
            exp_n = kk + 3; exp_b[1] = 8'h01; exp_b[2] = 8'(kk);
            for (int i = 0; i < kk; i++) exp_b[i + 3] = 8'(n * 16 + 1 + i);
         end
         ack_read(1'b0, n > DEPTH - 2 ? "R10" : "R6");
      end

      // R5 auto-poll dropped while bus reply pending
      bus_xfer(1'b0, 2, 8'hA0);
      bus_xfer(1'b1, 3, 8'hB0);
      exp_n = 5; exp_b[0] = 8'h10; exp_b[1] = 8'h01; exp_b[2] = 8'h02;
      exp_b[3] = 8'hA0; exp_b[4] = 8'hA1;
      ack_read(1'b0, "R5");

      // R5 empty auto-poll does nothing; R3 empty ack
      bus_xfer(1'b1, 0, 8'h00);
      @(negedge clk);
      chk("R5", "irq_n after empty auto-poll", int'(a_irq), 1);
      exp_n = 1; exp_b[0] = 8'h00;
      ack_read(1'b0, "R3");

      // R9 ack held during stream is ignored
      bus_xfer(1'b1, DEPTH, 8'hC0);
      @(posedge clk); #1;
      cmd_valid = 1'b1; cmd_op = 1'b0; cmd_argc = 8'd0;
      @(posedge clk); #1;
      got_n = 0;
      for (int k = 0; k < 64; k++) begin
         @(negedge clk);
         if (!a_valid) break;
         got[got_n] = a_byte;
         got_n++;
         if (got_n == 3) cmd_valid = 1'b0;
         if (a_last) break;
      end
      cmd_valid = 1'b0;
      exp_n = DEPTH + 1; exp_b[0] = 8'h14;
      for (int i = 0; i < DEPTH; i++) exp_b[i + 1] = 8'hC0 + 8'(i);
      compare("R9");
      @(negedge clk);
      chk("R9", "no second stream", int'(a_valid), 0);
      exp_n = 1; exp_b[0] = 8'h00;
      ack_read(1'b0, "R9");

      // R7 tick period on the short-period copy
      set_mask(8'h01);
      cmd(1'b0, 0, 8'h00); repeat (20) @(posedge clk);
      cmd(1'b0, 0, 8'h00); repeat (20) @(posedge clk);
      wait_tick(c0);
      exp_n = 1; exp_b[0] = 8'h01;
      ack_read(1'b1, "R7");
      wait_tick(c1);
      ack_read(1'b1, "R7");
      wait_tick(c2);
      chk("R7", "tick interval 1", c2 - c1, TPER);
      ack_read(1'b1, "R7");
      wait_tick(c3);
      chk("R7", "tick interval 2", c3 - c2, TPER);

      // R2 bus-mode ack keeps the tick bit
      set_mask(8'h15);
      bus_xfer(1'b1, 2, 8'h70);
      exp_n = 3; exp_b[0] = 8'h14; exp_b[1] = 8'h70; exp_b[2] = 8'h71;
      ack_read(1'b1, "R2");
      exp_n = 1; exp_b[0] = 8'h01;
      ack_read(1'b1, "R2");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule